// File: doc/BRIEF.md
# Tagged Data RAM with Shared Flag Bit

This block is a data RAM in which every 16-bit word has one extra flag bit attached to it. Software-visible commands set or clear that bit through two paths that reach the same storage. One path takes a word index. The other takes a byte address, which is twice the word index; its low bit is ignored, so both bytes of a word share one flag.

Reads always take a byte address. A read is either a whole word or a single byte, zero-extended to 16 bits. A word read ignores the low address bit. A byte read at an even address returns the upper byte and at an odd address the lower byte. Every read also copies the addressed word's flag into a TAG status output. TAG and the read data are registered, appear one cycle after the request, and hold until the next read. A plain word load port fills the data array and never touches a flag.

Top module: `tagged_ram`

## Requirements
- R1: While reset is low at a clock edge, every flag is cleared, and `rd_data` and `tag_out` become 0 after that edge.
- R2: A set or clear on the word flag port changes the flag of word `fw_addr` at the next edge; a later read of that word shows the new value on `tag_out`.
- R3: A set or clear on the byte flag port at byte address 2N or 2N+1 changes the flag of word N (bit 0 of `fb_addr` is ignored).
- R4: When any clear and any set hit the same word in one cycle, from either port or both, the flag ends up 0.
- R5: A word read (`rd_byte`=0) at byte address 2N or 2N+1 returns word N on `rd_data` one cycle later.
- R6: A byte read (`rd_byte`=1) at odd address 2N+1 returns bits 7:0 of word N in `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R7: A byte read at even address 2N returns bits 15:8 of word N in `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R8: Every read, word or byte, at either byte of word N loads word N's flag into `tag_out` one cycle later.
- R9: With `rd_en` low, `rd_data` and `tag_out` keep their values, even while flags or data change.
- R10: A read in the same cycle as a flag update or data load to that word returns the values held before that edge.
- R11: A data load through `wr_en` leaves the loaded word's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Load one data word |
| wr_addr | input | ADDR_W | Word index for the load |
| wr_data | input | 16 | Data to load |
| fw_set | input | 1 | Set flag, word-addressed port |
| fw_clr | input | 1 | Clear flag, word-addressed port |
| fw_addr | input | ADDR_W | Word index for the word flag port |
| fb_set | input | 1 | Set flag, byte-addressed port |
| fb_clr | input | 1 | Clear flag, byte-addressed port |
| fb_addr | input | ADDR_W+1 | Byte address for the byte flag port |
| rd_en | input | 1 | Read request |
| rd_byte | input | 1 | 1 = byte read, 0 = word read |
| rd_addr | input | ADDR_W+1 | Byte address of the read |
| rd_data | output | 16 | Registered read data |
| tag_out | output | 1 | Registered TAG status, the flag of the last word read |

## Verification
The bench builds the block with `ADDR_W`=4, which gives 16 words and a 5-bit byte address. This keeps the load of every word short and puts both ends of the array, word 0 and word 15 (byte addresses 30 and 31), within easy reach. That size still keeps separate indices for the word and byte flag ports. Those ports can then aim at the same word or at different words in one cycle, which brings the clear-over-set priority across ports and the pre-update read behaviour into directed tests.

// File: rtl/tram_pkg.sv
// Shared constants and types for the tagged data RAM.
package tram_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    // Read width selector, decoded from the rd_byte pin.
    typedef enum logic {
        RD_WORD = 1'b0,
        RD_BYTE = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/tram_flag_bank.sv
// Flag storage: one bit per word, set or cleared from a word-indexed
// and a byte-derived index. Assumes both indices are already word
// indices. A clear from either source beats any set to the same word.
module tram_flag_bank #(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_set,
    input  logic              w_clr,
    input  logic [ADDR_W-1:0] w_idx,
    input  logic              b_set,
    input  logic              b_clr,
    input  logic [ADDR_W-1:0] b_idx,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic              rd_flag
);
    logic [DEPTH-1:0] flags;

    for (genvar i = 0; i < DEPTH; i++) begin : g_flag
        logic set_hit;
        logic clr_hit;
        assign set_hit = (w_set && w_idx == ADDR_W'(i)) || (b_set && b_idx == ADDR_W'(i));
        assign clr_hit = (w_clr && w_idx == ADDR_W'(i)) || (b_clr && b_idx == ADDR_W'(i));

        // Update one flag bit; clear has priority over set.
        always_ff @(posedge clk) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (clr_hit) flags[i] <= 1'b0;
            else if (set_hit) flags[i] <= 1'b1;
        end
    end

    // Present the flag of the word being read (pre-update value).
    assign rd_flag = flags[rd_idx];

    // R2 and R4: a word-port clear always leaves the bit at 0.
    a_r2_word_clear: assert property (@(posedge clk) disable iff (!rst_n)
        w_clr |=> !flags[$past(w_idx)]);
    // R3 and R4: a byte-port clear always leaves the bit at 0.
    a_r3_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
        b_clr |=> !flags[$past(b_idx)]);
    // R2: an uncontested word-port set leaves the bit at 1.
    a_r2_word_set: assert property (@(posedge clk) disable iff (!rst_n)
        (w_set && !w_clr && !(b_clr && b_idx == w_idx)) |=> flags[$past(w_idx)]);
endmodule

// File: rtl/tram_data_bank.sv
// Data storage: DEPTH words of 16 bits, written one word per cycle,
// read asynchronously. No reset; contents are defined by loads only.
module tram_data_bank
    import tram_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store a loaded word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Present the addressed word (value before any same-cycle load).
    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/tram_read_port.sv
// Read path: turns a byte address into a word index, picks word or
// byte, zero-extends bytes and registers data together with TAG.
// Assumes word_in and flag_in belong to word_idx in the same cycle.
module tram_read_port
    import tram_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int BADDR_W = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  rd_mode_e           rd_mode,
    input  logic [BADDR_W-1:0] rd_baddr,
    input  logic [DATA_W-1:0]  word_in,
    input  logic               flag_in,
    output logic [ADDR_W-1:0]  word_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic               tag_out
);
    logic [DATA_W-1:0] sel_data;

    assign word_idx = rd_baddr[BADDR_W-1:1];

    // Choose the whole word or one zero-extended byte (odd = low byte).
    always_comb begin
        if (rd_mode == RD_WORD)
            sel_data = word_in;
        else if (rd_baddr[0])
            sel_data = {{(DATA_W-BYTE_W){1'b0}}, word_in[BYTE_W-1:0]};
        else
            sel_data = {{(DATA_W-BYTE_W){1'b0}}, word_in[DATA_W-1:BYTE_W]};
    end

    // Capture data and TAG on a read; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            tag_out <= 1'b0;
        end else if (rd_en) begin
            rd_data <= sel_data;
            tag_out <= flag_in;
        end
    end

    // R1: reset clears both outputs.
    a_r1_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !tag_out));
    // R9: outputs hold while no read is issued.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && $stable(tag_out)));
    // R6 and R7: a byte read leaves the upper half zero.
    a_r6_r7_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_mode == RD_BYTE) |=> rd_data[DATA_W-1:BYTE_W] == '0);
endmodule

// File: rtl/tagged_ram.sv
// Top level of the tagged data RAM: data bank, flag bank and read
// port. The byte flag port drops its low address bit so both bytes
// of a word map to the same flag.
module tagged_ram
    import tram_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int BADDR_W = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [15:0]        wr_data,
    input  logic               fw_set,
    input  logic               fw_clr,
    input  logic [ADDR_W-1:0]  fw_addr,
    input  logic               fb_set,
    input  logic               fb_clr,
    input  logic [BADDR_W-1:0] fb_addr,
    input  logic               rd_en,
    input  logic               rd_byte,
    input  logic [BADDR_W-1:0] rd_addr,
    output logic [15:0]        rd_data,
    output logic               tag_out
);
    logic [ADDR_W-1:0] rd_idx;
    logic [DATA_W-1:0] rd_word;
    logic              rd_flag;
    logic              fb_lsb_unused;
    rd_mode_e          rd_mode;

    assign fb_lsb_unused = fb_addr[0];
    assign rd_mode       = rd_mode_e'(rd_byte);

    tram_data_bank #(.ADDR_W(ADDR_W)) u_data (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    tram_flag_bank #(.ADDR_W(ADDR_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_set   (fw_set),
        .w_clr   (fw_clr),
        .w_idx   (fw_addr),
        .b_set   (fb_set),
        .b_clr   (fb_clr),
        .b_idx   (fb_addr[BADDR_W-1:1]),
        .rd_idx  (rd_idx),
        .rd_flag (rd_flag)
    );

    tram_read_port #(.ADDR_W(ADDR_W)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_mode  (rd_mode),
        .rd_baddr (rd_addr),
        .word_in  (rd_word),
        .flag_in  (rd_flag),
        .word_idx (rd_idx),
        .rd_data  (rd_data),
        .tag_out  (tag_out)
    );

    // R8 and R10: TAG follows the pre-edge flag of the word read.
    a_r8_tag_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> tag_out == $past(rd_flag));
    // R5 and R10: a word read returns the pre-edge stored word.
    a_r5_word_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_byte) |=> rd_data == $past(rd_word));
endmodule

// File: tb/tb_tagged_ram.sv
// Directed bench for tagged_ram: one task per scenario.
module tb_tagged_ram;
    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 0, fw_set = 0, fw_clr = 0, fb_set = 0, fb_clr = 0;
    logic          rd_en = 0, rd_byte = 0;
    logic [AW-1:0] wr_addr = '0, fw_addr = '0;
    logic [AW:0]   fb_addr = '0, rd_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   rd_data;
    logic          tag_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    tagged_ram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fw_set(fw_set), .fw_clr(fw_clr), .fw_addr(fw_addr),
        .fb_set(fb_set), .fb_clr(fb_clr), .fb_addr(fb_addr),
        .rd_en(rd_en), .rd_byte(rd_byte), .rd_addr(rd_addr),
        .rd_data(rd_data), .tag_out(tag_out)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    function automatic logic [15:0] pat(int n);
        return 16'hA5C3 ^ (16'(n) * 16'h1357);
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; fw_set = 0; fw_clr = 0; fb_set = 0; fb_clr = 0; rd_en = 0;
    endtask

    // Issue one read and sample at the following falling edge.
    task automatic rd(logic [AW:0] a, logic b, output logic [15:0] d, output logic t);
        @(negedge clk); idle(); rd_en = 1; rd_byte = b; rd_addr = a;
        @(negedge clk); idle(); d = rd_data; t = tag_out;
    endtask

    task automatic word_flag(logic [AW-1:0] w, logic s, logic c);
        @(negedge clk); idle(); fw_addr = w; fw_set = s; fw_clr = c;
        @(negedge clk); idle();
    endtask

    task automatic byte_flag(logic [AW:0] a, logic s, logic c);
        @(negedge clk); idle(); fb_addr = a; fb_set = s; fb_clr = c;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        logic [15:0] d; logic t;
        @(negedge clk); check("R1 rd_data", rd_data, 16'h0); check("R1 tag", {15'b0, tag_out}, 16'h0);
        rst_n = 1;
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk); wr_en = 1; wr_addr = AW'(i); wr_data = pat(i);
        end
        @(negedge clk); idle();
        rd({AW'(7), 1'b0}, 0, d, t); check("R1 flag clear", {15'b0, t}, 16'h0);
    endtask

    task automatic t_word_flag();
        logic [15:0] d; logic t;
        word_flag(3, 1, 0);
        rd({AW'(3), 1'b0}, 0, d, t); check("R2 set tag", {15'b0, t}, 16'h1);
        check("R5 word 3", d, pat(3));
        rd({AW'(2), 1'b0}, 0, d, t); check("R2 neighbour", {15'b0, t}, 16'h0);
        word_flag(3, 0, 1);
        rd({AW'(3), 1'b0}, 0, d, t); check("R2 cleared tag", {15'b0, t}, 16'h0);
    endtask

    task automatic t_byte_flag();
        logic [15:0] d; logic t;
        byte_flag({AW'(5), 1'b1}, 1, 0);   // odd byte of word 5
        rd({AW'(5), 1'b0}, 1, d, t); check("R3 odd set seen at even", {15'b0, t}, 16'h1);
        rd({AW'(5), 1'b1}, 1, d, t); check("R8 odd byte tag", {15'b0, t}, 16'h1);
        byte_flag({AW'(5), 1'b0}, 0, 1);
        rd({AW'(5), 1'b1}, 1, d, t); check("R3 even clear", {15'b0, t}, 16'h0);
        byte_flag({AW'(15), 1'b1}, 1, 0);
        rd({AW'(15), 1'b0}, 0, d, t); check("R3 top word", {15'b0, t}, 16'h1);
        check("R5 top word data", d, pat(15));
    endtask

    task automatic t_clear_wins();
        logic [15:0] d; logic t;
        word_flag(8, 1, 0);
        @(negedge clk); idle(); fw_addr = 8; fw_set = 1; fw_clr = 1;
        @(negedge clk); idle();
        rd({AW'(8), 1'b0}, 0, d, t); check("R4 same port", {15'b0, t}, 16'h0);
        @(negedge clk); idle(); fw_addr = 8; fw_set = 1; fb_addr = {AW'(8), 1'b1}; fb_clr = 1;
        @(negedge clk); idle();
        rd({AW'(8), 1'b0}, 0, d, t); check("R4 cross port", {15'b0, t}, 16'h0);
        @(negedge clk); idle(); fw_addr = 9; fw_clr = 1; fb_addr = {AW'(9), 1'b0}; fb_set = 1;
        @(negedge clk); idle();
        rd({AW'(9), 1'b0}, 0, d, t); check("R4 cross port rev", {15'b0, t}, 16'h0);
    endtask

    task automatic t_reads();
        logic [15:0] d; logic t;
        rd({AW'(6), 1'b1}, 0, d, t); check("R5 odd word read", d, pat(6));
        rd({AW'(0), 1'b0}, 0, d, t); check("R5 word 0", d, pat(0));
        rd({AW'(6), 1'b1}, 1, d, t); check("R6 low byte", d, {8'h0, pat(6)[7:0]});
        rd({AW'(6), 1'b0}, 1, d, t); check("R7 high byte", d, {8'h0, pat(6)[15:8]});
        rd({AW'(15), 1'b1}, 1, d, t); check("R6 top low", d, {8'h0, pat(15)[7:0]});
        check("R8 top byte tag", {15'b0, t}, 16'h1);
    endtask

    task automatic t_hold();
        logic [15:0] d; logic t;
        rd({AW'(15), 1'b0}, 0, d, t);
        word_flag(15, 0, 1);
        @(negedge clk); wr_en = 1; wr_addr = 15; wr_data = 16'h1234;
        @(negedge clk); idle(); @(negedge clk);
        check("R9 data held", rd_data, pat(15));
        check("R9 tag held", {15'b0, tag_out}, 16'h1);
        @(negedge clk); wr_en = 1; wr_addr = 15; wr_data = pat(15);
        @(negedge clk); idle();
    endtask

    task automatic t_same_cycle();
        logic [15:0] d; logic t;
        @(negedge clk); idle(); fw_addr = 10; fw_set = 1; wr_en = 1; wr_addr = 10; wr_data = 16'hBEEF;
        rd_en = 1; rd_byte = 0; rd_addr = {AW'(10), 1'b0};
        @(negedge clk); idle();
        check("R10 old tag", {15'b0, tag_out}, 16'h0);
        check("R10 old data", rd_data, pat(10));
        rd({AW'(10), 1'b0}, 0, d, t);
        check("R10 new tag", {15'b0, t}, 16'h1); check("R10 new data", d, 16'hBEEF);
    endtask

    task automatic t_write_keeps_flag();
        logic [15:0] d; logic t;
        @(negedge clk); idle(); wr_en = 1; wr_addr = 10; wr_data = 16'h0F0F;
        @(negedge clk); idle();
        rd({AW'(10), 1'b1}, 1, d, t);
        check("R11 flag kept", {15'b0, t}, 16'h1); check("R11 data", d, 16'h000F);
    endtask

    initial begin
        t_reset();
        t_word_flag();
        t_byte_flag();
        t_clear_wins();
        t_reads();
        t_hold();
        t_same_cycle();
        t_write_keeps_flag();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule